// File: doc/BRIEF.md
# Branch Clock Gating Controller

This block decides, cycle by cycle, which branch clocks of a chip are allowed to toggle. Every branch hangs off one base clock chosen at build time. Software sets three control bits per branch: a run bit that asks for the clock, an auto bit that makes switching off wait for the bus master on that branch to confirm it has gone quiet, and a wake bit that makes the branch take part in power-down. For each bit, each branch can have its own build option: software can change it, or it is fixed at 0 or at 1. This lets vital branches be pinned on.

A power-down pulse stops every branch that has its wake bit set. A wake pulse ends power-down, and those branches come back on. For each base clock an idle flag goes high once no branch fed by that base is running, so the clock generator upstream can stop that base without harm. The outputs are registered gate enables, intended for downstream glitch-free gating cells.

Top module: `clk_branch_ctrl`

## Requirements
- R1: The register word for a branch holds the run bit in bit 0, the auto bit in bit 1 and the wake bit in bit 2. A read also returns the branch's on/off status in bit 3. A bit fixed by the build reads its fixed value, and writes to it have no effect. A bit that software can change reads back the last value written.
- R2: While reset is held, every gate enable and status bit is 0. After reset, every bit that software can change reads 1 for run and 0 for auto and wake. Every branch whose base clock is running turns on within a few cycles of reset release.
- R3: With auto clear and no power-down active, a branch's gate enable follows its run bit, one clock after the register write.
- R4: A branch whose base-running input is low keeps its gate enable at 0, even with run set. It turns on one cycle after the base runs again.
- R5: One clock after a power-down pulse, power-down mode is active. One clock after that, every branch with its wake bit set is off. Branches with wake clear keep their state.
- R6: A wake pulse ends power-down mode on the next clock, and the affected branches turn on one clock later. While power-down mode is active, rewriting run does not bring back a branch that power-down switched off. If power-down and wake arrive together, wake wins.
- R7: The idle flag of a base is 1 exactly when every branch mapped to that base has its gate enable at 0. In the default build, branches 0 and 1 map to base 0, and branches 2 and 3 map to base 1.
- R8: A branch built with run fixed at 1 and wake and auto fixed at 0 stays on whenever its base runs, whatever software writes.
- R9: With auto set, a branch that should go off first raises its disable request for one clock and keeps its gate on. The gate turns off, and the request drops, on the clock after the request is seen together with the acknowledge. No gate with auto set falls without that handshake.
- R10: The status bit of a branch equals its gate enable, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | ADDR_W | Branch index for reads and writes |
| reg_wr | input | 1 | Write strobe for the addressed branch register |
| reg_wdata | input | 3 | Write data: bit 2 wake, bit 1 auto, bit 0 run |
| reg_rdata | output | 4 | Read data: bit 3 status, bits 2..0 control bits |
| pd_enter | input | 1 | Pulse that enters power-down mode |
| wake_evt | input | 1 | Pulse that leaves power-down mode |
| base_run | input | N_BASE | One bit per base clock, high while that base runs |
| mdis_ack | input | N_BRANCH | Bus-master-disabled acknowledge per branch |
| mdis_req | output | N_BRANCH | Bus-master-disable request per branch |
| gate_en | output | N_BRANCH | Registered clock-gate enable per branch |
| base_idle | output | N_BASE | High when no branch of that base is running |

## Verification
The bench builds the block with four branches on two bases. Branch 0 is a fixed safe branch. Branches 1 and 2 have all bits writable. Branch 3 has only run writable and wake fixed at 1. Under this setup, a sweep over all eight write values, for every branch and every base-running pattern, reaches every tie combination, both idle-flag outcomes and the base-off override, at a cost of a few hundred cycles. Directed sequences then cover the power-down and wake orderings, including the simultaneous case, and the stalled and completed auto handshake.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int CFG_W  = 3;
  localparam int RD_W   = 4;
  localparam int RUN_B  = 0;
  localparam int AUTO_B = 1;
  localparam int WAKE_B = 2;
  localparam int STAT_B = 3;

  typedef struct packed {
    logic wake;
    logic autom;
    logic run;
  } cbc_cfg_t;

  localparam logic [CFG_W-1:0] CFG_RST = 3'b001;
endpackage

// File: rtl/cbc_rst_sync.sv
module cbc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/cbc_cfg_reg.sv
module cbc_cfg_reg
  import cbc_pkg::*;
#(
  parameter logic [CFG_W-1:0] WR_MASK = 3'b111,
  parameter logic [CFG_W-1:0] TIE_VAL = 3'b000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  cbc_cfg_t wdata,
  output cbc_cfg_t cfg
);
  logic [CFG_W-1:0] wbits;
  logic [CFG_W-1:0] bits;

  assign wbits = wdata;

  for (genvar b = 0; b < CFG_W; b++) begin : g_bit
    if (WR_MASK[b]) begin : g_rw
      logic bit_q, bit_d;
      always_comb begin
        bit_d = bit_q;
        if (wr_en) bit_d = wbits[b];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= CFG_RST[b];
        else        bit_q <= bit_d;
      end
      assign bits[b] = bit_q;
    end else begin : g_tie
      assign bits[b] = TIE_VAL[b];
    end
  end

  assign cfg = bits;
endmodule

// File: rtl/cbc_pd_ctrl.sv
module cbc_pd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_enter,
  input  logic wake_evt,
  output logic pd_mode
);
  logic pd_q, pd_d;

  always_comb begin
    pd_d = pd_q;
    if (pd_enter) pd_d = 1'b1;
    if (wake_evt) pd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= 1'b0;
    else        pd_q <= pd_d;
  end

  assign pd_mode = pd_q;

  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !pd_mode); // R6
  AST_PD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_enter && !wake_evt) |=> pd_mode); // R5
endmodule

// File: rtl/cbc_branch_gate.sv
module cbc_branch_gate
  import cbc_pkg::*;
#(
  parameter bit FIXED_ON = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cbc_cfg_t cfg,
  input  logic     base_ok,
  input  logic     pd_mode,
  input  logic     ack,
  output logic     gate_en,
  output logic     req,
  output logic     status
);
  logic want;
  logic hs_done;
  logic gate_q, gate_d;
  logic req_q, req_d;
  logic stat_q;

  assign want    = cfg.run & base_ok & ~(pd_mode & cfg.wake);
  assign hs_done = req_q & ack;

  always_comb begin
    gate_d = gate_q;
    req_d  = 1'b0;
    if (want) begin
      gate_d = 1'b1;
    end else if (gate_q) begin
      if (!cfg.autom || hs_done) gate_d = 1'b0;
      else                       req_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      req_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
      req_q  <= req_d;
      stat_q <= gate_q;
    end
  end

  assign gate_en = gate_q;
  assign req     = req_q;
  assign status  = stat_q;

  AST_ON_NEEDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(base_ok)); // R4
  AST_AUTO_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_q) && $past(cfg.autom)) |-> $past(req_q && ack)); // R9
  AST_REQ_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> gate_q); // R9
  AST_PD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode && cfg.wake && !cfg.autom) |=> !gate_q); // R5
  AST_STATUS_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |=> status); // R10

  if (FIXED_ON) begin : g_fixed
    AST_FIXED_ON: assert property (@(posedge clk) disable iff (!rst_n)
      base_ok |=> gate_q); // R8
  end
endmodule

// File: rtl/cbc_base_status.sv
module cbc_base_status #(
  parameter int N_BRANCH = 4,
  parameter int N_BASE   = 2,
  parameter logic [N_BRANCH*8-1:0] BASE_MAP = '0
) (
  input  logic [N_BRANCH-1:0] gate_en,
  output logic [N_BASE-1:0]   base_idle
);
  for (genvar j = 0; j < N_BASE; j++) begin : g_base
    logic [N_BRANCH-1:0] member;
    for (genvar i = 0; i < N_BRANCH; i++) begin : g_m
      localparam int BI = int'(BASE_MAP[i*8 +: 8]);
      assign member[i] = (BI == j);
    end
    assign base_idle[j] = ~|(gate_en & member);
  end
endmodule

// File: rtl/clk_branch_ctrl.sv
module clk_branch_ctrl
  import cbc_pkg::*;
#(
  parameter int N_BRANCH = 4,
  parameter int N_BASE   = 2,
  parameter int ADDR_W   = (N_BRANCH > 1) ? $clog2(N_BRANCH) : 1,
  parameter logic [N_BRANCH*8-1:0] BASE_MAP = {8'd1, 8'd1, 8'd0, 8'd0},
  parameter logic [N_BRANCH-1:0] RUN_WR  = 4'b1110,
  parameter logic [N_BRANCH-1:0] RUN_TV  = 4'b0001,
  parameter logic [N_BRANCH-1:0] AUTO_WR = 4'b0110,
  parameter logic [N_BRANCH-1:0] AUTO_TV = 4'b0000,
  parameter logic [N_BRANCH-1:0] WAKE_WR = 4'b0110,
  parameter logic [N_BRANCH-1:0] WAKE_TV = 4'b1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [CFG_W-1:0]    reg_wdata,
  output logic [RD_W-1:0]     reg_rdata,
  input  logic                pd_enter,
  input  logic                wake_evt,
  input  logic [N_BASE-1:0]   base_run,
  input  logic [N_BRANCH-1:0] mdis_ack,
  output logic [N_BRANCH-1:0] mdis_req,
  output logic [N_BRANCH-1:0] gate_en,
  output logic [N_BASE-1:0]   base_idle
);
  localparam int N_SLOT = 1 << ADDR_W;

  logic rst_n_s;
  logic pd_mode;
  logic [N_BRANCH-1:0] stat;
  logic [RD_W-1:0] rd_slot [N_SLOT];

  cbc_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  cbc_pd_ctrl u_pd (
    .clk(clk), .rst_n(rst_n_s), .pd_enter(pd_enter),
    .wake_evt(wake_evt), .pd_mode(pd_mode)
  );

  for (genvar i = 0; i < N_BRANCH; i++) begin : g_br
    localparam int BI = int'(BASE_MAP[i*8 +: 8]);
    localparam logic [CFG_W-1:0] WRM = {WAKE_WR[i], AUTO_WR[i], RUN_WR[i]};
    localparam logic [CFG_W-1:0] TVM = {WAKE_TV[i], AUTO_TV[i], RUN_TV[i]};
    localparam bit FIX = !RUN_WR[i] && RUN_TV[i] && !WAKE_WR[i] && !WAKE_TV[i]
                         && !AUTO_WR[i] && !AUTO_TV[i];
    cbc_cfg_t cfg;
    cbc_cfg_t wd;
    logic     sel_wr;

    assign wd     = reg_wdata;
    assign sel_wr = reg_wr && (reg_addr == ADDR_W'(i));

    cbc_cfg_reg #(.WR_MASK(WRM), .TIE_VAL(TVM)) u_cfg (
      .clk(clk), .rst_n(rst_n_s), .wr_en(sel_wr), .wdata(wd), .cfg(cfg)
    );

    cbc_branch_gate #(.FIXED_ON(FIX)) u_gate (
      .clk(clk), .rst_n(rst_n_s), .cfg(cfg), .base_ok(base_run[BI]),
      .pd_mode(pd_mode), .ack(mdis_ack[i]), .gate_en(gate_en[i]),
      .req(mdis_req[i]), .status(stat[i])
    );

    assign rd_slot[i] = {stat[i], cfg};
  end

  for (genvar s = N_BRANCH; s < N_SLOT; s++) begin : g_pad
    assign rd_slot[s] = '0;
  end

  assign reg_rdata = rd_slot[reg_addr];

  cbc_base_status #(.N_BRANCH(N_BRANCH), .N_BASE(N_BASE), .BASE_MAP(BASE_MAP)) u_bst (
    .gate_en(gate_en), .base_idle(base_idle)
  );

  AST_IDLE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (base_idle == {N_BASE{1'b1}} && base_run == '0) |=> base_idle == {N_BASE{1'b1}}); // R7
endmodule

// File: tb/tb_clk_branch_ctrl.sv
`timescale 1ns/1ps
module tb_clk_branch_ctrl;
  localparam logic [3:0] RUN_WR  = 4'b1110, RUN_TV  = 4'b0001;
  localparam logic [3:0] AUTO_WR = 4'b0110, AUTO_TV = 4'b0000;
  localparam logic [3:0] WAKE_WR = 4'b0110, WAKE_TV = 4'b1000;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] reg_addr;
  logic reg_wr;
  logic [2:0] reg_wdata;
  logic [3:0] reg_rdata;
  logic pd_enter, wake_evt;
  logic [1:0] base_run;
  logic [3:0] mdis_ack, mdis_req, gate_en;
  logic [1:0] base_idle;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [2:0] mcfg [4];

  always #2.5 clk = ~clk;

  clk_branch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pd_enter(pd_enter),
    .wake_evt(wake_evt), .base_run(base_run), .mdis_ack(mdis_ack),
    .mdis_req(mdis_req), .gate_en(gate_en), .base_idle(base_idle)
  );

  function automatic logic [2:0] eff(input int i, input logic [2:0] v);
    logic [2:0] m, t;
    m = {WAKE_WR[i], AUTO_WR[i], RUN_WR[i]};
    t = {WAKE_TV[i], AUTO_TV[i], RUN_TV[i]};
    return (v & m) | (t & ~m);
  endfunction

  function automatic int base_of(input int i);
    return (i < 2) ? 0 : 1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input int i, input logic [2:0] v);
    reg_addr = 2'(i); reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    mcfg[i] = eff(i, v);
  endtask

  task automatic pulse(input logic p, input logic w);
    pd_enter = p; wake_evt = w;
    @(negedge clk);
    pd_enter = 1'b0; wake_evt = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    pd_enter = 1'b0; wake_evt = 1'b0; base_run = 2'b11; mdis_ack = '0;
    cyc(3);
    chk("R2 gate in reset", gate_en, 4'b0000);
    chk("R7 idle in reset", base_idle, 2'b11);
    reg_addr = 2'd1; #0.1;
    chk("R2 status in reset", reg_rdata[3], 1'b0);
    rst_n = 1'b1;
    cyc(5);
    chk("R2 gates after reset", gate_en, 4'b1111);
    for (int i = 0; i < 4; i++) begin
      reg_addr = 2'(i); #0.1;
      mcfg[i] = eff(i, 3'b001);
      chk("R2 reset value", reg_rdata[2:0], mcfg[i]);
    end

    // Sweep: every base pattern, branch and write value (R1 R3 R4 R7 R8 R10)
    mdis_ack = 4'b1111;
    for (int bp = 0; bp < 4; bp++) begin
      base_run = 2'(bp);
      for (int i = 0; i < 4; i++) begin
        for (int v = 0; v < 8; v++) begin
          logic [3:0] eg;
          logic [1:0] ei;
          wr(i, 3'(v));
          cyc(4);
          reg_addr = 2'(i); #0.1;
          chk((i == 0) ? "R8 R1 readback" : "R1 readback", reg_rdata[2:0], mcfg[i]);
          for (int j = 0; j < 4; j++) eg[j] = mcfg[j][0] & base_run[base_of(j)];
          chk((bp == 3) ? "R3 gate" : "R4 gate", gate_en, eg);
          ei[0] = ~(eg[0] | eg[1]);
          ei[1] = ~(eg[2] | eg[3]);
          chk("R7 idle", base_idle, ei);
          chk("R10 status", reg_rdata[3], eg[i]);
        end
      end
    end
    mdis_ack = '0;

    // Power-down and wake (R5 R6 R7)
    base_run = 2'b11;
    wr(1, 3'b101); wr(2, 3'b001); wr(3, 3'b001);
    cyc(2);
    chk("R3 all on", gate_en, 4'b1111);
    pulse(1'b1, 1'b0);
    chk("R5 one cycle lag", gate_en, 4'b1111);
    cyc(1);
    chk("R5 pd gates", gate_en, 4'b0101);
    wr(1, 3'b101);
    cyc(2);
    chk("R6 stays off in pd", gate_en, 4'b0101);
    pulse(1'b0, 1'b1);
    cyc(1);
    chk("R6 wake restores", gate_en, 4'b1111);
    pulse(1'b1, 1'b1);
    cyc(2);
    chk("R6 wake wins", gate_en, 4'b1111);
    wr(2, 3'b000);
    pulse(1'b1, 1'b0);
    cyc(2);
    chk("R7 base1 idle in pd", base_idle, 2'b10);
    chk("R5 gates", gate_en, 4'b0001);
    pulse(1'b0, 1'b1);
    cyc(2);
    chk("R6 after wake", gate_en, 4'b1011);
    chk("R7 after wake", base_idle, 2'b00);

    // Auto handshake (R9 R10)
    wr(1, 3'b011);
    cyc(2);
    chk("R9 on before", gate_en[1], 1'b1);
    wr(1, 3'b010);
    cyc(1);
    chk("R9 req raised", mdis_req[1], 1'b1);
    chk("R9 gate held", gate_en[1], 1'b1);
    cyc(3);
    chk("R9 still waiting req", mdis_req[1], 1'b1);
    chk("R9 still waiting gate", gate_en[1], 1'b1);
    mdis_ack[1] = 1'b1;
    cyc(1);
    chk("R9 gate off after ack", gate_en[1], 1'b0);
    chk("R9 req dropped", mdis_req[1], 1'b0);
    reg_addr = 2'd1; #0.1;
    chk("R10 status lags", reg_rdata[3], 1'b1);
    cyc(1);
    reg_addr = 2'd1; #0.1;
    chk("R10 status follows", reg_rdata[3], 1'b0);
    mdis_ack = '0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule